// File: doc/BRIEF.md
# Serial Receive Status and Exception Prioritizer

This block holds the receive-side status of a synchronous serial port and turns it into prioritized interrupt requests. A shifter pulses `word_done` with a completed word. The block latches that word into a holding register, keeps a receive-full flag, and detects overrun. An overrun happens when a new word lands while the previous one is still unread. The overrun flag can only be cleared by a fixed clear sequence: a status read followed by a data read.

Six interrupt sources are ranked in a fixed order. The two receive sources are derived internally, and they are mutually exclusive:

- **Receive with exception:** needs full and overrun together.
- **Error-free receive:** needs full with no overrun.

The four transmit-side and last-slot sources arrive as placeholder request inputs. Each source is gated by its own enable bit. A 3-bit code names the highest pending source.

Two small state machines carry the state.

The holding machine has two states:
- `HOLD_EMPTY` goes to `HOLD_FULL` when a word arrives.
- `HOLD_FULL` goes back to `HOLD_EMPTY` on a data read with no word in the same cycle.
- `HOLD_FULL` stays in `HOLD_FULL` on a word, whether or not a read happens in the same cycle.

The overrun sequencer has three states:
- `OVR_NONE` goes to `OVR_SEEN` on an overrun.
- `OVR_SEEN` goes to `OVR_ARMED` on a status read with no word in the same cycle.
- `OVR_ARMED` goes back to `OVR_SEEN` on any word, which cancels the arm.
- `OVR_ARMED` goes to `OVR_NONE` on a data read with no word in the same cycle.

Top module: `rxstat_top`

## Requirements
- R1: After reset, `stat_full`=0, `stat_ovr`=0, `rx_data`=0, both receive interrupts are 0, `irq_pending`=0 and `irq_vec`=7.
- R2: A `word_done` pulse loads `word_in` into `rx_data` and sets `stat_full` on the following clock edge.
- R3: A `data_rd` with no `word_done` in the same cycle clears `stat_full`. When `word_done` and `data_rd` occur together, `stat_full` stays 1, the new word is loaded and no overrun is flagged.
- R4: An overrun occurs when `word_done` arrives while `stat_full`=1 and `data_rd`=0. It sets `stat_ovr`, overwrites `rx_data` with the new word, and leaves `stat_full` at 1.
- R5: `stat_ovr` clears only when a `stat_rd` is followed later by a `data_rd`, with no `word_done` in between or in the cycle of the `data_rd`. A `data_rd` without a preceding `stat_rd` leaves it set.
- R6: A `word_done` after an arming `stat_rd` cancels the arm, including one in the same cycle as the `data_rd`. The next `data_rd` then leaves `stat_ovr` set.
- R7: `irq_rx_exc` = `ien[0]` & `stat_full` & `stat_ovr`.
- R8: `irq_rx` = `ien[1]` & `stat_full` & !`stat_ovr`. `irq_rx` and `irq_rx_exc` are never 1 together.
- R9: `irq_vec` gives the lowest-numbered active source. The codes are: 0 receive-with-exception, 1 error-free receive, 2 transmit exception, 3 transmit data, 4 receive last slot, 5 transmit last slot. It reads 7 when none is active. `irq_pending` is 1 exactly when a source is active.
- R10: Source 2+i (for i = 0..3) is active only when `aux_req[i]` and `ien[2+i]` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_done | input | 1 | Shifter completed a word |
| word_in | input | W | Completed word |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Receive data register read strobe |
| ien | input | 6 | Per-source interrupt enables, bit n for source code n |
| aux_req | input | 4 | Placeholder requests for sources 2..5 |
| rx_data | output | W | Holding register contents |
| stat_full | output | 1 | Receive-full flag |
| stat_ovr | output | 1 | Overrun flag |
| irq_rx_exc | output | 1 | Receive-with-exception request |
| irq_rx | output | 1 | Error-free receive request |
| irq_pending | output | 1 | Any source active |
| irq_vec | output | 3 | Code of highest-priority active source |

## Verification
A table walks the enable and auxiliary-request patterns while the receive side is idle. It shows whether the priority chain picks the lowest index and whether each enable gates only its own source.

Directed sequences then exercise the receive state:
- **Single words:** separate the plain full path from the overrun path.
- **A word coinciding with a read:** separates a simultaneous word-and-read from a true overrun.
- **Read orderings:** a bare data read, status-then-data, status-then-word-then-data, and status-then-word-with-data. These tell a correct clear sequence apart from one that ignores the arming order or the cancel rule.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
    localparam int NSRC    = 6;
    localparam int VEC_W   = 3;
    localparam int NAUX    = NSRC - 2;
    localparam logic [VEC_W-1:0] VEC_NONE = '1;

    localparam int SRC_RX_EXC = 0;
    localparam int SRC_RX     = 1;
    localparam int SRC_AUX0   = 2;

    typedef enum logic {
        HOLD_EMPTY,
        HOLD_FULL
    } hold_state_t;

    typedef enum logic [1:0] {
        OVR_NONE,
        OVR_SEEN,
        OVR_ARMED
    } ovr_state_t;
endpackage

// File: rtl/rxstat_hold.sv
module rxstat_hold
    import rxstat_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         word_done,
    input  logic [W-1:0] word_in,
    input  logic         data_rd,
    output logic         full,
    output logic [W-1:0] data,
    output logic         ovr_evt
);
    hold_state_t state_q, state_d;
    logic [W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HOLD_EMPTY;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (word_done) data_q <= word_in;
        end
    end

    always_comb begin
        state_d = state_q;
        ovr_evt = 1'b0;
        unique case (state_q)
            HOLD_EMPTY: begin
                if (word_done) state_d = HOLD_FULL;
            end
            HOLD_FULL: begin
                if (word_done) begin
                    state_d = HOLD_FULL;
                    ovr_evt = !data_rd;
                end else if (data_rd) begin
                    state_d = HOLD_EMPTY;
                end
            end
            default: state_d = HOLD_EMPTY;
        endcase
    end

    assign full = (state_q == HOLD_FULL);
    assign data = data_q;

    // R2
    full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> (full && data == $past(word_in)));

    // R4
    overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && full && !data_rd) |=> (full && data == $past(word_in)));
endmodule

// File: rtl/rxstat_ovr.sv
module rxstat_ovr
    import rxstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_evt,
    input  logic word_done,
    input  logic stat_rd,
    input  logic data_rd,
    output logic ovr
);
    ovr_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OVR_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OVR_NONE: begin
                if (ovr_evt) state_d = OVR_SEEN;
            end
            OVR_SEEN: begin
                if (stat_rd && !word_done) state_d = OVR_ARMED;
            end
            OVR_ARMED: begin
                if (word_done)    state_d = OVR_SEEN;
                else if (data_rd) state_d = OVR_NONE;
            end
            default: state_d = OVR_NONE;
        endcase
    end

    assign ovr = (state_q != OVR_NONE);

    // R4
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> ovr);

    // R5
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr) |-> ($past(data_rd) && !$past(word_done)));
endmodule

// File: rtl/rxstat_prio.sv
module rxstat_prio
    import rxstat_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int VW = VEC_W
) (
    input  logic [N-1:0]  req,
    output logic          pending,
    output logic [VW-1:0] vec
);
    logic [N:0]   above;
    logic [N-1:0] grant;
    logic [VW-1:0] vec_or;

    assign above[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]   = req[i] & ~above[i];
        assign above[i+1] = above[i] | req[i];
    end

    always_comb begin
        vec_or = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) vec_or = vec_or | VW'(i);
        end
    end

    assign pending = above[N];
    assign vec     = pending ? vec_or : '1;

    // R9
    grant_onehot_chk: assert final ($onehot0(grant));

    // R9
    vec_range_chk: assert final (!pending || (int'(vec) < N));
endmodule

// File: rtl/rxstat_top.sv
module rxstat_top
    import rxstat_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_done,
    input  logic [W-1:0]     word_in,
    input  logic             stat_rd,
    input  logic             data_rd,
    input  logic [NSRC-1:0]  ien,
    input  logic [NAUX-1:0]  aux_req,
    output logic [W-1:0]     rx_data,
    output logic             stat_full,
    output logic             stat_ovr,
    output logic             irq_rx_exc,
    output logic             irq_rx,
    output logic             irq_pending,
    output logic [VEC_W-1:0] irq_vec
);
    logic            ovr_evt;
    logic [NSRC-1:0] req;

    rxstat_hold #(.W(W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_done (word_done),
        .word_in   (word_in),
        .data_rd   (data_rd),
        .full      (stat_full),
        .data      (rx_data),
        .ovr_evt   (ovr_evt)
    );

    rxstat_ovr u_ovr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovr_evt   (ovr_evt),
        .word_done (word_done),
        .stat_rd   (stat_rd),
        .data_rd   (data_rd),
        .ovr       (stat_ovr)
    );

    assign irq_rx_exc = ien[SRC_RX_EXC] & stat_full &  stat_ovr;
    assign irq_rx     = ien[SRC_RX]     & stat_full & ~stat_ovr;

    always_comb begin
        req = '0;
        req[SRC_RX_EXC] = irq_rx_exc;
        req[SRC_RX]     = irq_rx;
        for (int i = 0; i < NAUX; i++) begin
            req[SRC_AUX0+i] = aux_req[i] & ien[SRC_AUX0+i];
        end
    end

    rxstat_prio #(.N(NSRC), .VW(VEC_W)) u_prio (
        .req     (req),
        .pending (irq_pending),
        .vec     (irq_vec)
    );

    // R8
    irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_rx && irq_rx_exc));

    // R1
    reset_vec_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!stat_full && !stat_ovr));
endmodule

// File: tb/tb_rxstat_top.sv
`timescale 1ns/1ps
module tb_rxstat_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         word_done = 1'b0;
    logic [W-1:0] word_in = '0;
    logic         stat_rd = 1'b0;
    logic         data_rd = 1'b0;
    logic [5:0]   ien = '0;
    logic [3:0]   aux_req = '0;
    logic [W-1:0] rx_data;
    logic         stat_full, stat_ovr, irq_rx_exc, irq_rx, irq_pending;
    logic [2:0]   irq_vec;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    rxstat_top #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .word_done(word_done), .word_in(word_in),
        .stat_rd(stat_rd), .data_rd(data_rd), .ien(ien), .aux_req(aux_req),
        .rx_data(rx_data), .stat_full(stat_full), .stat_ovr(stat_ovr),
        .irq_rx_exc(irq_rx_exc), .irq_rx(irq_rx), .irq_pending(irq_pending),
        .irq_vec(irq_vec)
    );

    // {ien, aux_req, expected vec, expected pending}, receive side idle
    localparam int NROW = 10;
    localparam logic [13:0] TBL [NROW] = '{
        {6'h00, 4'hF, 3'd7, 1'b0},
        {6'h3F, 4'hF, 3'd2, 1'b1},
        {6'h3F, 4'hE, 3'd3, 1'b1},
        {6'h3F, 4'hC, 3'd4, 1'b1},
        {6'h3F, 4'h8, 3'd5, 1'b1},
        {6'h3F, 4'h0, 3'd7, 1'b0},
        {6'h20, 4'hF, 3'd5, 1'b1},
        {6'h14, 4'hA, 3'd7, 1'b0},
        {6'h18, 4'h6, 3'd3, 1'b1},
        {6'h03, 4'hF, 3'd7, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic wd, input logic [W-1:0] w, input logic sr, input logic dr);
        @(negedge clk);
        word_done = wd; word_in = w; stat_rd = sr; data_rd = dr;
        @(posedge clk);
        #1;
        word_done = 1'b0; stat_rd = 1'b0; data_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 full", 32'(stat_full), 0);
        check("R1 ovr", 32'(stat_ovr), 0);
        check("R1 data", 32'(rx_data), 0);
        check("R1 irq", 32'({irq_rx_exc, irq_rx, irq_pending}), 0);
        check("R1 vec", 32'(irq_vec), 7);

        // R9 R10 priority table
        for (int r = 0; r < NROW; r++) begin
            @(negedge clk);
            ien = TBL[r][13:8];
            aux_req = TBL[r][7:4];
            #1;
            check("R9 R10 vec", 32'(irq_vec), 32'(TBL[r][3:1]));
            check("R9 pending", 32'(irq_pending), 32'(TBL[r][0]));
        end

        ien = 6'h3F; aux_req = 4'h0;
        // R2 R8 first word
        step(1'b1, 8'hA5, 1'b0, 1'b0);
        check("R2 full", 32'(stat_full), 1);
        check("R2 data", 32'(rx_data), 32'h A5);
        check("R8 irq_rx", 32'(irq_rx), 1);
        check("R7 irq_rx_exc", 32'(irq_rx_exc), 0);
        check("R9 vec rx", 32'(irq_vec), 1);
        ien[1] = 1'b0; #1;
        check("R8 gated", 32'(irq_rx), 0);
        check("R9 vec none", 32'(irq_vec), 7);
        ien[1] = 1'b1;

        // R3 read empties
        step(1'b0, 8'h00, 1'b0, 1'b1);
        check("R3 full clr", 32'(stat_full), 0);
        check("R8 irq_rx off", 32'(irq_rx), 0);

        // R3 word with read same cycle
        step(1'b1, 8'h11, 1'b0, 1'b0);
        step(1'b1, 8'h22, 1'b0, 1'b1);
        check("R3 full kept", 32'(stat_full), 1);
        check("R3 no ovr", 32'(stat_ovr), 0);
        check("R3 data", 32'(rx_data), 32'h22);

        // R4 R7 overrun
        step(1'b1, 8'h33, 1'b0, 1'b0);
        check("R4 ovr", 32'(stat_ovr), 1);
        check("R4 full", 32'(stat_full), 1);
        check("R4 data", 32'(rx_data), 32'h33);
        check("R7 exc", 32'(irq_rx_exc), 1);
        check("R8 rx masked", 32'(irq_rx), 0);
        check("R9 vec exc", 32'(irq_vec), 0);
        aux_req = 4'hF; #1;
        check("R9 exc over aux", 32'(irq_vec), 0);
        aux_req = 4'h0;
        ien[0] = 1'b0; #1;
        check("R7 gated", 32'(irq_rx_exc), 0);
        check("R8 still masked", 32'(irq_rx), 0);
        ien[0] = 1'b1;

        // R5 data read without status read
        step(1'b0, 8'h00, 1'b0, 1'b1);
        check("R5 bare read", 32'(stat_ovr), 1);
        check("R5 full", 32'(stat_full), 0);
        // R5 status then data
        step(1'b0, 8'h00, 1'b1, 1'b0);
        check("R5 armed still set", 32'(stat_ovr), 1);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        check("R5 cleared", 32'(stat_ovr), 0);

        // R6 cancel by word between
        step(1'b1, 8'h44, 1'b0, 1'b0);
        step(1'b1, 8'h55, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        step(1'b1, 8'h66, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        check("R6 cancel", 32'(stat_ovr), 1);
        check("R6 full", 32'(stat_full), 0);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        check("R5 clear after rearm", 32'(stat_ovr), 0);

        // R6 word in same cycle as data read
        step(1'b1, 8'h88, 1'b0, 1'b0);
        step(1'b1, 8'h99, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        step(1'b1, 8'h77, 1'b0, 1'b1);
        check("R6 same cycle", 32'(stat_ovr), 1);
        check("R3 full", 32'(stat_full), 1);
        check("R3 data", 32'(rx_data), 32'h77);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        check("R6 later read", 32'(stat_ovr), 1);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b1);
        check("R5 final clear", 32'(stat_ovr), 0);
        check("R9 idle vec", 32'(irq_vec), 7);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule